// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash device that is driven through a command-set protocol on a simple synchronous bus. A host writes opcodes and data over several bus cycles. The block decodes each sequence and acts on a small internal array that is split into equal sectors. The supported sequences are:

- single-word program
- sector erase with confirm
- buffered multi-word write
- status read
- identification read
- query-table read
- lock/unlock

A read-only input blocks every change to the array and records the refused attempt in the status byte.

The opcode latched on the first write cycle decides where reads are steered. Reads can come from the array, from the status byte, from the identification codes or from a small constant query ROM. Later write cycles advance a cycle counter, and the meaning of each cycle depends on the latched opcode. A sector erase runs as a sequential fill of one word per clock. During the fill the ready flag stays low and incoming writes are ignored.

Accesses are naturally aligned. The access size is 1, 2 or 4 bytes, limited to the bus width. Byte order is chosen on each access. Read data is presented one clock after the read strobe.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the device is in read-array mode, the status byte is 0x00 and `rvalid` is low.
- R2: A read in read-array mode returns the addressed bytes. The access size is given by `acc_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). With `big_endian` = 0 the lowest address sits in bits [7:0]. With `big_endian` = 1 the lowest address sits in the most significant used byte. `rvalid` is high exactly one clock after `rd_en`.
- R3: Opcode 0x10 or 0x40, followed by a data write, stores the data at that address using the access size and byte order of the data write. It then sets status bit 7. Reads return the status byte until a new opcode is written.
- R4: Opcode 0x20 followed by 0xD0 fills the whole sector that holds the confirm address with 0xFF. The address is aligned down to the sector start. While the fill runs, status bit 7 reads 0. Bit 7 is set when the fill completes.
- R5: After opcode 0x20, a second write of 0xFF or of any value other than 0xD0 returns the device to read-array mode and leaves the array unchanged.
- R6: Opcode 0xE8 is followed by a count N. The next N+1 writes each store one word at their own address. A final 0xD0 sets the status cycle back to idle, and reads keep returning status. Any other final value returns the device to read-array mode.
- R7: While `ro` is high, a program or buffered data write sets status bit 4, and an erase confirm sets status bit 5. Both also set bit 7. The array is left unchanged.
- R8: Opcode 0x50 clears the whole status byte and returns the device to read-array mode.
- R9: Opcode 0x70 selects status reads. The status byte is returned zero-extended in bits [7:0]. Bit 7 means ready, bit 5 means an erase was refused and bit 4 means a program was refused.
- R10: Opcode 0x90 selects identification reads. The word index is the low 8 address bits shifted right by log2(bus bytes). Index 0 returns the manufacturer code, index 1 returns the device code and any other index returns 0.
- R11: Opcode 0x98 selects query reads. The index is formed as in R10 and selects one byte of the query ROM:
  - 0x10, 0x11, 0x12: "Q", "R", "Y"
  - 0x27: log2 of the array size in bytes
  - 0x2D: sector count minus 1

  An index at or above `QRY_LEN` returns 0. Later writes other than 0xFF keep the device in query mode, and 0xFF leaves it.
- R12: In the first cycle, 0xFF, 0xF0, 0x00 or any unrecognised opcode returns the device to read-array mode.
- R13: Opcode 0x60 followed by 0xD0 or 0x01 sets status bit 7, and reads keep returning status. Any other second value returns the device to read-array mode.
- R14: Writes that arrive while an erase fill is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ro | input | 1 | Read-only: blocks every array change |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8*BUS_BYTES | Write data; bits [7:0] carry opcodes |
| acc_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| big_endian | input | 1 | Byte order of this access |
| rdata | output | 8*BUS_BYTES | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one clock after rd_en |

## Verification
The assertions check the following properties on every cycle:
- ready stays low while an erase fill runs and is high when the fill ends;
- the third and fourth write cycles occur only under a buffered write;
- a clear-status write leaves status 0 in read-array mode;
- a refused program raises bit 4;
- writes during a fill leave the latched command unchanged;
- the read-valid timing is as specified.

Other behaviour can only be shown by the bench scenarios, because it depends on the array contents seen afterwards. This covers byte steering under both byte orders, the alignment of an erase to its sector, the refused array changes under read-only, the identification and query values, and the abort paths.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_BUFWR   = 8'hE8;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_LOCKALT = 8'h01;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDLE    = 8'h00;

  localparam int ST_READY   = 7;
  localparam int ST_ERS_ERR = 5;
  localparam int ST_PRG_ERR = 4;

  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_IDENT, SRC_QUERY} rd_src_e;

  function automatic rd_src_e src_of(input logic [7:0] c);
    case (c)
      OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_STATUS, OP_BUFWR: return SRC_STATUS;
      OP_IDENT: return SRC_IDENT;
      OP_QUERY: return SRC_QUERY;
      default:  return SRC_ARRAY;
    endcase
  endfunction

  function automatic logic is_prog(input logic [7:0] c);
    return (c == OP_PROG_A) || (c == OP_PROG_B);
  endfunction
endpackage

// File: rtl/nor_lane_array.sv
module nor_lane_array #(
  parameter int LANES = 4,
  parameter int WORDS = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [LANES-1:0]         wmask,
  input  logic [LANES*8-1:0]       wdata,
  input  logic                     re,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [LANES*8-1:0]       rdata
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0] mem [WORDS];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (we && wmask[j]) mem[waddr] <= wdata[j*8 +: 8];
      if (re) q <= mem[raddr];
    end
    assign rdata[j*8 +: 8] = q;
  end
endmodule

// File: rtl/nor_info_rom.sv
module nor_info_rom #(
  parameter int          BUS_BYTES    = 4,
  parameter int          SECTOR_BYTES = 64,
  parameter int          SECTORS      = 4,
  parameter int          QRY_LEN      = 49,
  parameter logic [15:0] MANUF_ID     = 16'h0089,
  parameter logic [15:0] DEVICE_ID    = 16'h0018
) (
  input  logic [7:0]  addr8,
  output logic [15:0] id_val,
  output logic [7:0]  qry_val
);
  localparam int LANE_W    = $clog2(BUS_BYTES);
  localparam int TOT_LOG2  = $clog2(SECTOR_BYTES * SECTORS);
  localparam int SEC_M1    = SECTORS - 1;

  logic [7:0] idx;
  assign idx = addr8 >> LANE_W;

  always_comb begin
    case (idx)
      8'd0:    id_val = MANUF_ID;
      8'd1:    id_val = DEVICE_ID;
      default: id_val = 16'h0000;
    endcase
  end

  always_comb begin
    qry_val = 8'h00;
    if (int'(idx) < QRY_LEN) begin
      case (idx)
        8'h10: qry_val = 8'h51;
        8'h11: qry_val = 8'h52;
        8'h12: qry_val = 8'h59;
        8'h13: qry_val = 8'h01;
        8'h15: qry_val = 8'h31;
        8'h1B: qry_val = 8'h45;
        8'h1C: qry_val = 8'h55;
        8'h27: qry_val = 8'(TOT_LOG2);
        8'h28: qry_val = 8'h02;
        8'h2C: qry_val = 8'h01;
        8'h2D: qry_val = 8'(SEC_M1);
        8'h2E: qry_val = 8'(SEC_M1 >> 8);
        8'h2F: qry_val = 8'(SECTOR_BYTES >> 8);
        8'h30: qry_val = 8'(SECTOR_BYTES >> 16);
        default: qry_val = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WADDR_W = 6,
  parameter int SEC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ro,
  input  logic               wr_en,
  input  logic [7:0]         op,
  input  logic [WADDR_W-1:0] wr_word,
  input  logic [LANES-1:0]   wr_mask,
  input  logic [LANES*8-1:0] wr_lanes,
  output logic [7:0]         cmd_o,
  output logic [7:0]         status_o,
  output logic               arr_we,
  output logic [WADDR_W-1:0] arr_addr,
  output logic [LANES-1:0]   arr_mask,
  output logic [LANES*8-1:0] arr_data
);
  localparam int SIDX_W = WADDR_W - SEC_W;
  localparam logic [SEC_W-1:0] SEC_LAST = {SEC_W{1'b1}};

  logic [7:0]        cmd;
  logic [1:0]        cyc;
  logic [7:0]        status;
  logic [7:0]        remain;
  logic              erasing;
  logic [SEC_W-1:0]  fill_ptr;
  logic [SIDX_W-1:0] fill_sec;
  logic              data_cycle;

  assign cmd_o    = cmd;
  assign status_o = status;

  // a write that carries array data: program second cycle or buffered data cycle
  assign data_cycle = wr_en && !erasing &&
                      ((cyc == 2'd1 && is_prog(cmd)) || (cyc == 2'd2 && cmd == OP_BUFWR));

  always_comb begin
    if (erasing) begin
      arr_we   = 1'b1;
      arr_addr = {fill_sec, fill_ptr};
      arr_mask = '1;
      arr_data = '1;
    end else begin
      arr_we   = data_cycle && !ro;
      arr_addr = wr_word;
      arr_mask = wr_mask;
      arr_data = wr_lanes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= OP_IDLE;
      cyc      <= 2'd0;
      status   <= 8'h00;
      remain   <= 8'h00;
      erasing  <= 1'b0;
      fill_ptr <= '0;
      fill_sec <= '0;
    end else if (erasing) begin
      fill_ptr <= fill_ptr + 1'b1;
      if (fill_ptr == SEC_LAST) begin
        erasing          <= 1'b0;
        status[ST_READY] <= 1'b1;
      end
    end else if (wr_en) begin
      case (cyc)
        2'd0: begin
          case (op)
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY: begin
              cmd <= op;
              cyc <= 2'd1;
            end
            OP_BUFWR: begin
              cmd              <= op;
              cyc              <= 2'd1;
              status[ST_READY] <= 1'b1;
            end
            OP_STATUS, OP_IDENT: cmd <= op;
            OP_CLEAR: begin
              status <= 8'h00;
              cmd    <= OP_IDLE;
            end
            default: cmd <= OP_IDLE;
          endcase
        end
        2'd1: begin
          if (is_prog(cmd)) begin
            if (ro) status[ST_PRG_ERR] <= 1'b1;
            status[ST_READY] <= 1'b1;
            cyc              <= 2'd0;
          end else if (cmd == OP_ERASE) begin
            cyc <= 2'd0;
            if (op == OP_CONFIRM) begin
              if (ro) begin
                status[ST_ERS_ERR] <= 1'b1;
                status[ST_READY]   <= 1'b1;
              end else begin
                erasing          <= 1'b1;
                status[ST_READY] <= 1'b0;
                fill_ptr         <= '0;
                fill_sec         <= wr_word[WADDR_W-1:SEC_W];
              end
            end else begin
              cmd <= OP_IDLE;
            end
          end else if (cmd == OP_LOCK) begin
            cyc <= 2'd0;
            if (op == OP_CONFIRM || op == OP_LOCKALT) status[ST_READY] <= 1'b1;
            else cmd <= OP_IDLE;
          end else if (cmd == OP_QUERY) begin
            if (op == OP_ARRAY) begin
              cmd <= OP_IDLE;
              cyc <= 2'd0;
            end
          end else if (cmd == OP_BUFWR) begin
            remain <= op;
            cyc    <= 2'd2;
          end else begin
            cmd <= OP_IDLE;
            cyc <= 2'd0;
          end
        end
        2'd2: begin
          if (cmd == OP_BUFWR) begin
            if (ro) status[ST_PRG_ERR] <= 1'b1;
            status[ST_READY] <= 1'b1;
            if (remain == 8'h00) cyc <= 2'd3;
            else remain <= remain - 1'b1;
          end else begin
            cmd <= OP_IDLE;
            cyc <= 2'd0;
          end
        end
        default: begin
          cyc <= 2'd0;
          if (!(cmd == OP_BUFWR && op == OP_CONFIRM)) cmd <= OP_IDLE;
        end
      endcase
    end
  end

  // R4: ready is low for the whole fill and high once it ends
  assert_erase_busy_R4: assert property (@(posedge clk) disable iff (rst)
    erasing |-> !status[ST_READY]);
  assert_fill_done_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(erasing) |-> status[ST_READY]);
  // R6: cycles beyond the second only exist under a buffered write
  assert_late_cycle_buf_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2'd2) |-> (cmd == OP_BUFWR));
  // R8: clear-status leaves status 0 in read-array mode
  assert_clear_status_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !erasing && cyc == 2'd0 && op == OP_CLEAR) |=> (status == 8'h00 && cmd == OP_IDLE));
  // R7: refused program raises the program-error flag
  assert_ro_prog_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (data_cycle && ro) |=> status[ST_PRG_ERR]);
  // R14: writes during a fill leave the command unchanged
  assert_fill_ignores_R14: assert property (@(posedge clk) disable iff (rst)
    (erasing && wr_en) |=> $stable(cmd));
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_cmd_pkg::*;
#(
  parameter int          BUS_BYTES    = 4,
  parameter int          SECTOR_BYTES = 64,
  parameter int          SECTORS      = 4,
  parameter int          QRY_LEN      = 49,
  parameter logic [15:0] MANUF_ID     = 16'h0089,
  parameter logic [15:0] DEVICE_ID    = 16'h0018,
  localparam int         DATA_W       = 8 * BUS_BYTES,
  localparam int         ADDR_W       = $clog2(SECTOR_BYTES * SECTORS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ro,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        acc_size,
  input  logic              big_endian,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int WORDS     = (SECTOR_BYTES * SECTORS) / BUS_BYTES;
  localparam int WADDR_W   = $clog2(WORDS);
  localparam int SEC_WORDS = SECTOR_BYTES / BUS_BYTES;
  localparam int SEC_W     = $clog2(SEC_WORDS);
  localparam int LANE_W    = $clog2(BUS_BYTES);
  localparam int OFF_W     = (LANE_W > 0) ? LANE_W : 1;

  logic [WADDR_W-1:0] word;
  logic [OFF_W-1:0]   off;
  logic [2:0]         sz;
  logic [BUS_BYTES-1:0] wr_mask;
  logic [DATA_W-1:0]  wr_lanes;
  logic [7:0]         cmd, status;
  logic               arr_we;
  logic [WADDR_W-1:0] arr_addr;
  logic [BUS_BYTES-1:0] arr_mask;
  logic [DATA_W-1:0]  arr_data;
  logic [DATA_W-1:0]  lane_q;
  logic [15:0]        id_val;
  logic [7:0]         qry_val;

  rd_src_e            src_q;
  logic [OFF_W-1:0]   off_q;
  logic [2:0]         sz_q;
  logic               be_q;
  logic [15:0]        info_q;
  logic [7:0]         stat_q;

  assign word = WADDR_W'(addr >> LANE_W);
  assign off  = OFF_W'(int'(addr) % BUS_BYTES);

  always_comb begin
    case (acc_size)
      2'd0:    sz = 3'd1;
      2'd1:    sz = 3'd2;
      default: sz = 3'd4;
    endcase
    if (int'(sz) > BUS_BYTES) sz = 3'(BUS_BYTES);
  end

  // place the bytes of a write onto the lanes they address
  always_comb begin
    wr_mask  = '0;
    wr_lanes = '0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (k < int'(sz) && (int'(off) + k) < BUS_BYTES) begin
        wr_mask[int'(off) + k] = 1'b1;
        if (big_endian) wr_lanes[(int'(off) + k)*8 +: 8] = wdata[(int'(sz) - 1 - k)*8 +: 8];
        else            wr_lanes[(int'(off) + k)*8 +: 8] = wdata[k*8 +: 8];
      end
    end
  end

  nor_cmd_seq #(.LANES(BUS_BYTES), .WADDR_W(WADDR_W), .SEC_W(SEC_W)) u_seq (
    .clk(clk), .rst(rst), .ro(ro), .wr_en(wr_en), .op(wdata[7:0]),
    .wr_word(word), .wr_mask(wr_mask), .wr_lanes(wr_lanes),
    .cmd_o(cmd), .status_o(status),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_mask(arr_mask), .arr_data(arr_data)
  );

  nor_lane_array #(.LANES(BUS_BYTES), .WORDS(WORDS)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wmask(arr_mask), .wdata(arr_data),
    .re(rd_en), .raddr(word), .rdata(lane_q)
  );

  nor_info_rom #(
    .BUS_BYTES(BUS_BYTES), .SECTOR_BYTES(SECTOR_BYTES), .SECTORS(SECTORS),
    .QRY_LEN(QRY_LEN), .MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID)
  ) u_rom (
    .addr8(8'(addr)), .id_val(id_val), .qry_val(qry_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      src_q  <= SRC_ARRAY;
      off_q  <= '0;
      sz_q   <= 3'd1;
      be_q   <= 1'b0;
      info_q <= 16'h0000;
      stat_q <= 8'h00;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        src_q  <= src_of(cmd);
        off_q  <= off;
        sz_q   <= sz;
        be_q   <= big_endian;
        info_q <= (src_of(cmd) == SRC_IDENT) ? id_val : {8'h00, qry_val};
        stat_q <= status;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (src_q)
      SRC_ARRAY: begin
        for (int k = 0; k < BUS_BYTES; k++) begin
          if (k < int'(sz_q) && (int'(off_q) + k) < BUS_BYTES) begin
            if (be_q) rdata[(int'(sz_q) - 1 - k)*8 +: 8] = lane_q[(int'(off_q) + k)*8 +: 8];
            else      rdata[k*8 +: 8]                    = lane_q[(int'(off_q) + k)*8 +: 8];
          end
        end
      end
      SRC_STATUS: rdata = DATA_W'(stat_q);
      default:    rdata = DATA_W'(info_q);
    endcase
  end

  // R2: read data is valid exactly one clock after the strobe
  assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  assert_read_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid);
endmodule

// File: tb/sim_nor_cmd_flash.sv
`timescale 1ns/1ps
module sim_nor_cmd_flash;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WT = 2'd2;
  localparam int NV = 32;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        be;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam logic [80:0] TBL [NV] = '{
    {K_WR, 8'h00, 32'h20, 2'd2, 1'b0, 32'h0, 4'd4},        // R4 erase setup
    {K_WR, 8'h05, 32'hD0, 2'd2, 1'b0, 32'h0, 4'd4},        // R4 confirm, aligns to 0x00
    {K_RD, 8'h00, 32'h0, 2'd2, 1'b0, 32'h00, 4'd4},        // R4 busy
    {K_WT, 8'h00, 32'd20, 2'd2, 1'b0, 32'h0, 4'd4},
    {K_RD, 8'h00, 32'h0, 2'd2, 1'b0, 32'h80, 4'd4},        // R4 done
    {K_WR, 8'h00, 32'hFF, 2'd2, 1'b0, 32'h0, 4'd12},
    {K_RD, 8'h3C, 32'h0, 2'd2, 1'b0, 32'hFFFFFFFF, 4'd4},  // R4 last word
    {K_WR, 8'h00, 32'h40, 2'd2, 1'b0, 32'h0, 4'd3},
    {K_WR, 8'h08, 32'h11223344, 2'd2, 1'b0, 32'h0, 4'd3},
    {K_RD, 8'h08, 32'h0, 2'd2, 1'b0, 32'h80, 4'd3},        // R3 status after program
    {K_WR, 8'h00, 32'hFF, 2'd2, 1'b0, 32'h0, 4'd12},
    {K_RD, 8'h08, 32'h0, 2'd2, 1'b0, 32'h11223344, 4'd2},  // R2 LE word
    {K_RD, 8'h08, 32'h0, 2'd2, 1'b1, 32'h44332211, 4'd2},  // R2 BE word
    {K_RD, 8'h0A, 32'h0, 2'd1, 1'b0, 32'h00001122, 4'd2},  // R2 half
    {K_RD, 8'h09, 32'h0, 2'd0, 1'b0, 32'h00000033, 4'd2},  // R2 byte
    {K_WR, 8'h00, 32'h10, 2'd2, 1'b0, 32'h0, 4'd3},
    {K_WR, 8'h0E, 32'hABCD, 2'd1, 1'b1, 32'h0, 4'd3},      // R3 BE half
    {K_WR, 8'h00, 32'hFF, 2'd2, 1'b0, 32'h0, 4'd12},
    {K_RD, 8'h0C, 32'h0, 2'd2, 1'b0, 32'hCDABFFFF, 4'd3},
    {K_WR, 8'h00, 32'h90, 2'd2, 1'b0, 32'h0, 4'd10},
    {K_RD, 8'h00, 32'h0, 2'd2, 1'b0, 32'h0089, 4'd10},     // R10 manufacturer
    {K_RD, 8'h04, 32'h0, 2'd2, 1'b0, 32'h0018, 4'd10},     // R10 device
    {K_RD, 8'h08, 32'h0, 2'd2, 1'b0, 32'h0, 4'd10},        // R10 other index
    {K_WR, 8'h00, 32'h98, 2'd2, 1'b0, 32'h0, 4'd11},
    {K_RD, 8'h40, 32'h0, 2'd2, 1'b0, 32'h51, 4'd11},       // R11 'Q'
    {K_RD, 8'h9C, 32'h0, 2'd2, 1'b0, 32'h08, 4'd11},       // R11 size log2
    {K_RD, 8'hB4, 32'h0, 2'd2, 1'b0, 32'h03, 4'd11},       // R11 sectors-1
    {K_RD, 8'hC4, 32'h0, 2'd2, 1'b0, 32'h00, 4'd11},       // R11 past length
    {K_WR, 8'h00, 32'h12, 2'd2, 1'b0, 32'h0, 4'd11},
    {K_RD, 8'h44, 32'h0, 2'd2, 1'b0, 32'h52, 4'd11},       // R11 still query
    {K_WR, 8'h00, 32'hFF, 2'd2, 1'b0, 32'h0, 4'd11},
    {K_RD, 8'h08, 32'h0, 2'd2, 1'b0, 32'h11223344, 4'd11}  // R11 left query
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ro = 1'b0, wr_en = 1'b0, rd_en = 1'b0, big_endian = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  acc_size = 2'd2;
  logic [31:0] rdata;
  logic        rvalid;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nor_cmd_flash u0 (
    .clk(clk), .rst(rst), .ro(ro), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .acc_size(acc_size), .big_endian(big_endian),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [1:0] s = 2'd2, input logic b = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; acc_size = s; big_endian = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp,
                    input logic [1:0] s = 2'd2, input logic b = 1'b0);
    @(negedge clk);
    rd_en = 1'b1; addr = a; acc_size = s; big_endian = b;
    @(negedge clk);
    rd_en = 1'b0;
    chk({tag, " rvalid"}, {31'b0, rvalid}, 32'h1);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rvalid after reset", {31'b0, rvalid}, 32'h0);
    wr(8'h00, 32'h70);
    rd("R1 R9 status after reset", 8'h00, 32'h00);
    wr(8'h00, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      case (v.kind)
        K_WR: wr(v.addr, v.data, v.size, v.be);
        K_RD: rd($sformatf("R%0d vec %0d", v.req, i), v.addr, v.exp, v.size, v.be);
        default: repeat (int'(v.data)) @(negedge clk);
      endcase
    end

    // R5: erase abort and erase with wrong second value
    wr(8'h08, 32'h20); wr(8'h08, 32'hFF);
    rd("R5 abort keeps data", 8'h08, 32'h11223344);
    wr(8'h08, 32'h20); wr(8'h08, 32'h33);
    rd("R5 bad confirm to array", 8'h08, 32'h11223344);

    // R6: buffered write of two words, then one ending without confirm
    wr(8'h20, 32'hE8); wr(8'h20, 32'h01);
    wr(8'h20, 32'hAAAA5555); wr(8'h24, 32'h01020304); wr(8'h20, 32'hD0);
    rd("R6 status after confirm", 8'h20, 32'h80);
    wr(8'h00, 32'hFF);
    rd("R6 word 0", 8'h20, 32'hAAAA5555);
    rd("R6 word 1", 8'h24, 32'h01020304);
    wr(8'h28, 32'hE8); wr(8'h28, 32'h00); wr(8'h28, 32'h5A5A5A5A); wr(8'h28, 32'h77);
    rd("R6 bad confirm to array", 8'h28, 32'h5A5A5A5A);

    // R7: read-only refuses program and erase
    ro = 1'b1;
    wr(8'h00, 32'h40); wr(8'h08, 32'h00000000);
    rd("R7 program error flag", 8'h08, 32'h90);
    wr(8'h00, 32'h20); wr(8'h00, 32'hD0);
    rd("R7 erase error flag", 8'h00, 32'hB0);
    wr(8'h00, 32'hFF);
    rd("R7 word unchanged", 8'h08, 32'h11223344);
    rd("R7 sector not erased", 8'h20, 32'hAAAA5555);
    ro = 1'b0;

    // R8: clear status
    wr(8'h00, 32'h50);
    rd("R8 back to array", 8'h08, 32'h11223344);
    wr(8'h00, 32'h70);
    rd("R8 status cleared", 8'h00, 32'h00);

    // R13: lock / unlock
    wr(8'h00, 32'h60); wr(8'h00, 32'h01);
    rd("R13 lock sets ready", 8'h00, 32'h80);
    wr(8'h00, 32'h60); wr(8'h00, 32'h55);
    rd("R13 bad second to array", 8'h08, 32'h11223344);

    // R12: return-to-array opcodes
    wr(8'h00, 32'h70); wr(8'h00, 32'hF0);
    rd("R12 F0 to array", 8'h08, 32'h11223344);
    wr(8'h00, 32'h90); wr(8'h00, 32'h00);
    rd("R12 00 to array", 8'h08, 32'h11223344);
    wr(8'h00, 32'h90); wr(8'h00, 32'h3A);
    rd("R12 unknown to array", 8'h00, 32'hFFFFFFFF);

    // R14: writes during fill are ignored; erase aligned to sector 1
    wr(8'h40, 32'h20); wr(8'h47, 32'hD0);
    wr(8'h48, 32'h40); wr(8'h48, 32'h12345678);
    rd("R14 R4 busy during fill", 8'h48, 32'h00);
    repeat (20) @(negedge clk);
    rd("R14 R4 ready after fill", 8'h48, 32'h80);
    wr(8'h00, 32'hFF);
    rd("R14 ignored program", 8'h48, 32'hFFFFFFFF);
    rd("R4 sector start", 8'h40, 32'hFFFFFFFF);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule